// File: doc/BRIEF.md
# Track and Acquire Channel Sequencer

This block sequences acquisitions into a bank of held channel codes: a set of per-channel hold registers plus one extra register for an offset channel, each as wide as the converter result. A request names its target in one of three ways: one channel by address, the offset channel, or every channel at once (calibrate). A track level chooses between two behaviours. With track high, the capture starts immediately. With track low, the target is put into pass-through and the capture waits for a track rising edge. During a capture the sequencer starts an external converter, waits for its done strobe and stores the returned code. It also drives an active-low busy output that spans exactly the capture.

For every channel and for the offset channel, the block outputs a select bit. The bit is high while the output should follow the live input, which covers both waiting and capturing. It drops back to the held register in the cycle busy returns high. A bounded capture window, longer for calibrate, forces completion if the converter never answers. A combinational read port returns any stored code by index.

Top module: `acq_hold_sequencer`

## Requirements
- R1: After reset every hold register and the offset register read zero, `busy_n` is 1, `conv_start` is 0 and no live select is set.
- R2: A request sampled with `track` = 1 while idle or waiting makes `busy_n` 0 and `conv_start` 1 in the following cycle; `conv_start` is high for that single cycle.
- R3: A request sampled with `track` = 0 leaves `busy_n` at 1 and sets the target's live select. The capture starts in the cycle after a clock edge that samples `track` = 1 when the previous sample was 0.
- R4: A `conv_done` sampled during a capture stores `conv_code` into the target register(s), and `busy_n` returns to 1 in that same cycle. A `conv_done` outside a capture changes no register.
- R5: Without `conv_done`, a single-target capture keeps `busy_n` low for exactly SINGLE_CYC cycles and then ends, leaving the target register unchanged.
- R6: With `req_all` = 1 (precedence over `req_offset`) all NUM_CH channel registers take the code, the offset register is untouched, and the capture window is CAL_CYC cycles.
- R7: With `req_offset` = 1 and `req_all` = 0 the offset register is the target and `req_addr` is ignored.
- R8: A request sampled while `busy_n` is 0 is dropped: the capture and its target are unchanged, and `req_reject` is 1 for one cycle in the cycle that follows.
- R9: A new request while waiting for track replaces the pending target; the previous target's live select clears.
- R10: `rd_code` returns channel `rd_idx` for `rd_idx` < NUM_CH, the offset register for `rd_idx` = NUM_CH, and zero above that.
- R11: While `busy_n` is 0 the live selects of exactly the target set are 1: channel `req_addr` (bit position = address), all channel bits for calibrate, or `offs_live` for the offset channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Acquire request strobe |
| req_addr | input | 5 | Channel address (ADDR_W) |
| req_offset | input | 1 | Target the offset channel |
| req_all | input | 1 | Calibrate: target all channels |
| track | input | 1 | Track level; low defers capture |
| conv_done | input | 1 | Converter result ready |
| conv_code | input | 14 | Converter result (CODE_W) |
| conv_start | output | 1 | One-cycle converter start |
| busy_n | output | 1 | Low during a capture |
| req_reject | output | 1 | Request dropped while busy |
| out_live | output | 32 | Per-channel live-input select (NUM_CH) |
| offs_live | output | 1 | Offset channel live-input select |
| rd_idx | input | 6 | Readback index (IDX_W) |
| rd_code | output | 14 | Readback code |

## Verification
If the sequencer state is corrupted, `busy_n` stays low past the capture window, or `conv_start` appears without a falling busy, within one cycle of the fault. If the target latch is wrong, the live-select bits show it during the wait or the capture, before any register is written. A wrong write decode appears on the read port at the first readback after completion, because the bench sweeps every index after each operation. Rejected requests and stray done strobes are checked through the same sweep, which shows that nothing moved.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_HOLDOFF = 2'd1,
      ST_CAPTURE = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      TGT_CH   = 2'd0,
      TGT_OFFS = 2'd1,
      TGT_ALL  = 2'd2
   } tgt_kind_e;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
   import acq_seq_pkg::*;
#(
   parameter int NUM_CH     = 32,
   parameter int SINGLE_CYC = 800,
   parameter int CAL_CYC    = 2250,
   localparam int ADDR_W    = $clog2(NUM_CH),
   localparam int CNT_W     = $clog2(CAL_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_offset,
   input  logic              req_all,
   input  logic              track,
   input  logic              conv_done,
   output logic              busy_n,
   output logic              conv_start,
   output logic              req_reject,
   output logic              pending,
   output logic              wr_en,
   output tgt_kind_e         tgt_kind,
   output logic [ADDR_W-1:0] tgt_ch
);
   seq_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             track_q;
   logic             start_q;
   logic             rej_q;
   tgt_kind_e        req_kind;
   logic             track_rise;

   always_comb begin
      if (req_all)         req_kind = TGT_ALL;
      else if (req_offset) req_kind = TGT_OFFS;
      else                 req_kind = TGT_CH;
   end

   assign track_rise = track && !track_q;
   assign lim        = (tgt_kind == TGT_ALL) ? CNT_W'(CAL_CYC) : CNT_W'(SINGLE_CYC);
   assign busy_n     = (state != ST_CAPTURE);
   assign pending    = (state != ST_IDLE);
   assign wr_en      = (state == ST_CAPTURE) && conv_done;
   assign conv_start = start_q;
   assign req_reject = rej_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tgt_kind <= TGT_CH;
         tgt_ch   <= '0;
         cnt      <= '0;
         track_q  <= 1'b0;
         start_q  <= 1'b0;
         rej_q    <= 1'b0;
      end else begin
         track_q <= track;
         start_q <= 1'b0;
         rej_q   <= 1'b0;
         case (state)
            ST_IDLE, ST_HOLDOFF: begin
               if (req_valid) begin
                  tgt_kind <= req_kind;
                  tgt_ch   <= req_addr;
                  cnt      <= '0;
                  if (track) begin
                     state   <= ST_CAPTURE;
                     start_q <= 1'b1;
                  end else begin
                     state <= ST_HOLDOFF;
                  end
               end else if (state == ST_HOLDOFF && track_rise) begin
                  state   <= ST_CAPTURE;
                  start_q <= 1'b1;
                  cnt     <= '0;
               end
            end
            ST_CAPTURE: begin
               if (req_valid) rej_q <= 1'b1;
               if (conv_done || cnt == lim - 1'b1) state <= ST_IDLE;
               else                                cnt   <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_n) |-> conv_start);
   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPTURE) |-> (cnt < lim));
   assert_reject_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> $past(!busy_n));
   assert_write_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> busy_n);
endmodule

// File: rtl/hold_bank.sv
module hold_bank
   import acq_seq_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int CODE_W  = 14,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int IDX_W  = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  tgt_kind_e         tgt_kind,
   input  logic [ADDR_W-1:0] tgt_ch,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CODE_W-1:0] rd_code,
   output logic [NUM_CH-1:0] tgt_mask,
   output logic              offs_hit
);
   logic [CODE_W-1:0] ch_reg [NUM_CH];
   logic [CODE_W-1:0] offs_reg;

   assign offs_hit = (tgt_kind == TGT_OFFS);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign tgt_mask[i] = (tgt_kind == TGT_ALL) ||
                           ((tgt_kind == TGT_CH) && (tgt_ch == ADDR_W'(i)));
      always_ff @(posedge clk) begin
         if (!rst_n)                     ch_reg[i] <= '0;
         else if (wr_en && tgt_mask[i])  ch_reg[i] <= wr_code;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                offs_reg <= '0;
      else if (wr_en && offs_hit) offs_reg <= wr_code;
   end

   always_comb begin
      rd_code = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_idx == IDX_W'(i)) rd_code = ch_reg[i];
      if (rd_idx == IDX_W'(NUM_CH)) rd_code = offs_reg;
   end

   assert_cal_keeps_offs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tgt_kind == TGT_ALL) |=> $stable(offs_reg));
   assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_kind != TGT_ALL) |-> $onehot0({tgt_mask, offs_hit}));
endmodule

// File: rtl/acq_hold_sequencer.sv
module acq_hold_sequencer
   import acq_seq_pkg::*;
#(
   parameter int NUM_CH     = 32,
   parameter int CODE_W     = 14,
   parameter int SINGLE_CYC = 800,
   parameter int CAL_CYC    = 2250,
   localparam int ADDR_W    = $clog2(NUM_CH),
   localparam int IDX_W     = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_offset,
   input  logic              req_all,
   input  logic              track,
   input  logic              conv_done,
   input  logic [CODE_W-1:0] conv_code,
   output logic              conv_start,
   output logic              busy_n,
   output logic              req_reject,
   output logic [NUM_CH-1:0] out_live,
   output logic              offs_live,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CODE_W-1:0] rd_code
);
   if (NUM_CH < 2 || (1 << ADDR_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (SINGLE_CYC < 2 || CAL_CYC < SINGLE_CYC) begin : g_bad_win
      $error("capture windows need SINGLE_CYC >= 2 and CAL_CYC >= SINGLE_CYC");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("CODE_W must be positive");
   end

   logic              pending;
   logic              wr_en;
   tgt_kind_e         tgt_kind;
   logic [ADDR_W-1:0] tgt_ch;
   logic [NUM_CH-1:0] tgt_mask;
   logic              offs_hit;

   acq_ctrl #(
      .NUM_CH     (NUM_CH),
      .SINGLE_CYC (SINGLE_CYC),
      .CAL_CYC    (CAL_CYC)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_offset (req_offset),
      .req_all    (req_all),
      .track      (track),
      .conv_done  (conv_done),
      .busy_n     (busy_n),
      .conv_start (conv_start),
      .req_reject (req_reject),
      .pending    (pending),
      .wr_en      (wr_en),
      .tgt_kind   (tgt_kind),
      .tgt_ch     (tgt_ch)
   );

   hold_bank #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .tgt_kind (tgt_kind),
      .tgt_ch   (tgt_ch),
      .wr_code  (conv_code),
      .rd_idx   (rd_idx),
      .rd_code  (rd_code),
      .tgt_mask (tgt_mask),
      .offs_hit (offs_hit)
   );

   assign out_live  = pending ? tgt_mask : '0;
   assign offs_live = pending && offs_hit;

   assert_live_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> ($countones({out_live, offs_live}) >= 1));
   assert_live_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> (out_live == '0 && !offs_live));
endmodule

// File: tb/acq_hold_sequencer_test.sv
module acq_hold_sequencer_test;
   localparam int NCH = 32;
   localparam int CW  = 14;
   localparam int SGL = 40;
   localparam int CAL = 90;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [4:0]    req_addr = '0;
   logic          req_offset = 1'b0;
   logic          req_all = 1'b0;
   logic          track = 1'b1;
   logic          conv_done = 1'b0;
   logic [CW-1:0] conv_code = '0;
   logic          conv_start, busy_n, req_reject, offs_live;
   logic [NCH-1:0] out_live;
   logic [5:0]    rd_idx = '0;
   logic [CW-1:0] rd_code;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;
   logic [CW-1:0] model [NCH+1];

   always #10 clk = ~clk;

   acq_hold_sequencer #(.NUM_CH(NCH), .CODE_W(CW), .SINGLE_CYC(SGL), .CAL_CYC(CAL)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_offset(req_offset), .req_all(req_all), .track(track),
      .conv_done(conv_done), .conv_code(conv_code), .conv_start(conv_start),
      .busy_n(busy_n), .req_reject(req_reject), .out_live(out_live),
      .offs_live(offs_live), .rd_idx(rd_idx), .rd_code(rd_code));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NCH:0] exp_live(input int a, input bit off, input bit all);
      if (all)      return {1'b0, {NCH{1'b1}}};
      else if (off) return {1'b1, {NCH{1'b0}}};
      else          return (NCH+1)'(1) << a;
   endfunction

   function automatic void model_write(input int a, input bit off, input bit all,
                                       input logic [CW-1:0] c);
      if (all) for (int i = 0; i < NCH; i++) model[i] = c;
      else if (off) model[NCH] = c;
      else model[a] = c;
   endfunction

   task automatic sweep(input string tag);
      for (int i = 0; i < 64; i++) begin
         rd_idx = 6'(i);
         #1;
         chk(tag, rd_code, (i <= NCH) ? model[i] : '0);
      end
   endtask

   task automatic send(input int a, input bit off, input bit all, input bit trk);
      @(negedge clk);
      req_valid = 1; req_addr = 5'(a); req_offset = off; req_all = all; track = trk;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic finish_capture(input int a, input bit off, input bit all, input int d,
                                 input logic [CW-1:0] c);
      int lim = all ? CAL : SGL;
      chk("R2 busy low", busy_n, 0);
      chk("R2 start", conv_start, 1);
      chk("R11 live", {offs_live, out_live}, exp_live(a, off, all));
      if (d >= lim) begin
         repeat (lim - 1) @(negedge clk);
         chk(all ? "R6 window" : "R5 window", busy_n, 0);
         @(negedge clk);
         chk(all ? "R6 timeout" : "R5 timeout", busy_n, 1);
      end else begin
         if (d > 1) begin
            @(negedge clk);
            chk("R2 start pulse", conv_start, 0);
            repeat (d - 2) @(negedge clk);
         end
         conv_done = 1; conv_code = c;
         @(negedge clk);
         conv_done = 0;
         chk("R4 busy high", busy_n, 1);
         chk("R4 live cleared", {offs_live, out_live}, '0);
         model_write(a, off, all, c);
      end
   endtask

   task automatic acquire(input int a, input bit off, input bit all, input int d,
                          input logic [CW-1:0] c);
      send(a, off, all, 1'b1);
      finish_capture(a, off, all, d, c);
   endtask

   initial begin
      for (int i = 0; i <= NCH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 busy", busy_n, 1);
      chk("R1 start", conv_start, 0);
      chk("R1 live", {offs_live, out_live}, '0);
      sweep("R1 regs zero");

      acquire(5, 0, 0, 3, 14'h1234);
      sweep("R10 after single");
      acquire(17, 1, 0, 1, 14'h2ABC);
      sweep("R7 offset ignores address");
      acquire(0, 1, 1, 6, 14'h0F0F);
      sweep("R6 calibrate keeps offset");
      acquire(9, 0, 0, SGL, 14'h3333);
      sweep("R5 timeout keeps register");
      acquire(2, 0, 1, CAL, 14'h1111);
      sweep("R6 cal timeout");

      // reject during capture
      send(7, 0, 0, 1'b1);
      req_valid = 1; req_addr = 5'd8;
      @(negedge clk);
      req_valid = 0;
      chk("R8 reject pulse", req_reject, 1);
      chk("R8 still busy", busy_n, 0);
      chk("R8 target kept", {offs_live, out_live}, exp_live(7, 0, 0));
      conv_done = 1; conv_code = 14'h0777;
      @(negedge clk);
      conv_done = 0;
      chk("R8 reject one cycle", req_reject, 0);
      model_write(7, 0, 0, 14'h0777);
      sweep("R8 rejected request no write");

      // stray done while idle
      @(negedge clk); conv_done = 1; conv_code = 14'h3FFF;
      @(negedge clk); conv_done = 0;
      sweep("R4 done outside capture");

      // deferred capture
      send(12, 0, 0, 1'b0);
      chk("R3 busy stays high", busy_n, 1);
      chk("R3 live pass", {offs_live, out_live}, exp_live(12, 0, 0));
      repeat (5) @(negedge clk);
      chk("R3 still waiting", busy_n, 1);
      track = 1;
      @(negedge clk);
      finish_capture(12, 0, 0, 2, 14'h0ABC);
      sweep("R3 deferred write");

      // replacement while waiting
      send(3, 0, 0, 1'b0);
      send(20, 0, 0, 1'b0);
      chk("R9 replaced live", {offs_live, out_live}, exp_live(20, 0, 0));
      chk("R9 busy high", busy_n, 1);
      track = 1;
      @(negedge clk);
      finish_capture(20, 0, 0, 4, 14'h2468);
      sweep("R9 replaced write");

      // deferred offset
      send(0, 1, 0, 1'b0);
      chk("R3 offset live", {offs_live, out_live}, exp_live(0, 1, 0));
      track = 1;
      @(negedge clk);
      finish_capture(0, 1, 0, 2, 14'h1357);
      sweep("R7 deferred offset");

      // constrained random
      begin
         int seed = 7;
         void'($urandom(seed));
         for (int n = 0; n < 60; n++) begin
            int a = $urandom_range(NCH - 1);
            bit off = ($urandom_range(5) == 0);
            bit all = ($urandom_range(9) == 0);
            int d = ($urandom_range(12) == 0) ? CAL : $urandom_range(1, SGL - 1);
            logic [CW-1:0] c = CW'($urandom);
            if ($urandom_range(3) == 0) begin
               send(a, off, all, 1'b0);
               chk("R3 random wait", busy_n, 1);
               repeat ($urandom_range(4)) @(negedge clk);
               track = 1;
               @(negedge clk);
               finish_capture(a, off, all, d, c);
            end else begin
               acquire(a, off, all, d, c);
            end
            sweep("R10 random readback");
         end
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule